// File: doc/BRIEF.md
# Fetch-Block Branch Target Predictor

This block guesses, once per fetch block, whether that block contains a taken branch. It keys a set-associative branch target table on the aligned fetch-block base address. On a hit whose two-bit counter predicts taken, it raises a redirect one cycle later, carrying the stored target, so the fetch address logic can steer the next request there. Each table entry also records the lane within the block where the branch sits.

The prediction made for every request is placed in an in-order metadata queue. When the matching memory response comes back, the entry is removed from the queue. The block then produces a per-lane active mask and a per-lane predicted-taken flag, so that instructions after a predicted-taken branch are not passed on. Responses that belong to squashed fetches still remove their entry, but produce no annotation.

The execute stage trains the table through an update strobe. An update that hits moves the saturating counter. An update that misses claims a way in its set, and each set replaces its ways first-in first-out.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous reset, `redir_val` and `out_val` are 0 and the table holds no valid entry, so no lookup hits until an update allocates one.
- R2: A request whose block address hits a valid entry with counter bit 1 set gives `redir_val`=1 and `redir_target`=stored target in the next cycle. Any other request, or no request, gives `redir_val`=0 in that cycle.
- R3: The set index is `req_addr[OFS_W +: IDX_W]`, where OFS_W = log2(LANES)+2. The tag is `req_addr[ADDR_W-1:OFS_W]`. Each set holds WAYS entries: WAYS=1 gives a direct-mapped table and WAYS=ENTRIES gives a fully associative one.
- R4: An update that hits increments the counter when `upd_taken`=1 and decrements it when `upd_taken`=0. The counter saturates at 3 and at 0.
- R5: An update that misses allocates an entry for the block of `upd_pc`. It stores the target `upd_target` and the lane `upd_pc[OFS_W-1:2]`. The counter is set to 2 when `upd_taken`=1 and to 1 when `upd_taken`=0.
- R6: Within a set, allocation replaces ways in allocation order: once all WAYS ways are filled, the oldest allocated entry is replaced.
- R7: When a request and an update arrive in the same cycle, the lookup uses the table contents from before that update.
- R8: Each request pushes {predicted taken, lane} into a metadata queue of QDEPTH entries, and each `rsp_val` pops the oldest entry. A response with `rsp_drop`=0 gives `out_val`=1 one cycle later, annotated with that entry's metadata.
- R9: For a popped entry predicted taken at lane L, `out_active` bit i is 1 exactly for i ≤ L, and `out_taken` has only bit L set. For an entry not predicted taken, `out_active` is all ones and `out_taken` is 0.
- R10: A response with `rsp_drop`=1 still pops its entry but leaves `out_val`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_val | input | 1 | Fetch request issued this cycle |
| req_addr | input | ADDR_W | Fetch-block base address of the request |
| redir_val | output | 1 | Predicted-taken redirect for the previous request |
| redir_target | output | ADDR_W | Predicted target address |
| rsp_val | input | 1 | Memory response returns; pops one metadata entry |
| rsp_drop | input | 1 | Returning response belongs to a squashed fetch |
| out_val | output | 1 | Annotation valid for the previous response |
| out_active | output | LANES | Lanes to pass downstream |
| out_taken | output | LANES | Lane holding the predicted-taken branch |
| upd_val | input | 1 | Branch resolution update strobe |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The hardest case to reach from the ports is FIFO replacement in one set while other sets stay untouched. Another is a lookup that races an allocation for the same block in the same cycle. The stimulus reaches both on purpose. It sends three taken updates whose addresses differ only in the bits above the index, then probes each block to see which one was evicted. It also drives a request and an update for the same new block in one cycle. A random phase then draws blocks from a pool of four tags per set and interleaves requests, normal and dropped responses, and updates. A queue-based model tracks counters, evictions and metadata order on every clock.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // two-bit saturating direction counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  localparam logic [1:0] CTR_WEAK_T  = 2'b10;
  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LANES   = 4,
  parameter int ENTRIES = 16,
  parameter int WAYS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_msb,
  output logic [ADDR_W-1:0] lk_target,
  output logic [$clog2(LANES)-1:0] lk_lane,
  input  logic              up_val,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int LANE_W = $clog2(LANES);
  localparam int OFS_W  = LANE_W + 2;
  localparam int SETS   = ENTRIES / WAYS;
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W  = ADDR_W - OFS_W;

  logic              vld   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_m [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_m [SETS][WAYS];
  logic [1:0]        ctr_m [SETS][WAYS];
  logic [LANE_W-1:0] lane_m[SETS][WAYS];
  logic [WAY_W-1:0]  nxt   [SETS];

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return (SETS > 1) ? a[OFS_W +: IDX_W] : '0;
  endfunction

  logic [IDX_W-1:0] li, ui;
  logic [TAG_W-1:0] lt, ut;
  assign li = set_of(lk_addr);
  assign ui = set_of(up_pc);
  assign lt = lk_addr[ADDR_W-1:OFS_W];
  assign ut = up_pc[ADDR_W-1:OFS_W];

  always_comb begin
    lk_hit    = 1'b0;
    lk_msb    = 1'b0;
    lk_target = '0;
    lk_lane   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lk_hit && vld[li][w] && tag_m[li][w] == lt) begin
        lk_hit    = 1'b1;
        lk_msb    = ctr_m[li][w][1];
        lk_target = tgt_m[li][w];
        lk_lane   = lane_m[li][w];
      end
    end
  end

  logic             up_hit;
  logic [WAY_W-1:0] up_way;
  always_comb begin
    up_hit = 1'b0;
    up_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!up_hit && vld[ui][w] && tag_m[ui][w] == ut) begin
        up_hit = 1'b1;
        up_way = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        nxt[s] <= '0;
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
      end
    end else if (up_val) begin
      if (up_hit) begin
        ctr_m[ui][up_way] <= ctr_step(ctr_m[ui][up_way], up_taken);
      end else begin
        vld[ui][nxt[ui]]    <= 1'b1;
        tag_m[ui][nxt[ui]]  <= ut;
        tgt_m[ui][nxt[ui]]  <= up_target;
        lane_m[ui][nxt[ui]] <= up_pc[OFS_W-1:2];
        ctr_m[ui][nxt[ui]]  <= up_taken ? CTR_WEAK_T : CTR_WEAK_NT;
        nxt[ui] <= (nxt[ui] == WAY_W'(WAYS - 1)) ? '0 : nxt[ui] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/btb_meta_fifo.sv
module btb_meta_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rp, wp;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (!push && pop) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/btb_lane_mask.sv
module btb_lane_mask #(
  parameter int LANES = 4
) (
  input  logic                     taken,
  input  logic [$clog2(LANES)-1:0] lane,
  output logic [LANES-1:0]         active,
  output logic [LANES-1:0]         flag
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign active[i] = !taken || (i <= int'(lane));
    assign flag[i]   = taken && (i == int'(lane));
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W  = 32,
  parameter int LANES   = 4,
  parameter int ENTRIES = 16,
  parameter int WAYS    = 2,
  parameter int QDEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_val,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              redir_val,
  output logic [ADDR_W-1:0] redir_target,
  input  logic              rsp_val,
  input  logic              rsp_drop,
  output logic              out_val,
  output logic [LANES-1:0]  out_active,
  output logic [LANES-1:0]  out_taken,
  input  logic              upd_val,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int LANE_W = $clog2(LANES);
  localparam int META_W = LANE_W + 1;

  logic              lk_hit, lk_msb;
  logic [ADDR_W-1:0] lk_target;
  logic [LANE_W-1:0] lk_lane;
  logic              pred_tk;

  btb_table #(.ADDR_W(ADDR_W), .LANES(LANES), .ENTRIES(ENTRIES), .WAYS(WAYS)) u_tab (
    .clk(clk), .rst(rst),
    .lk_addr(req_addr), .lk_hit(lk_hit), .lk_msb(lk_msb),
    .lk_target(lk_target), .lk_lane(lk_lane),
    .up_val(upd_val), .up_pc(upd_pc), .up_taken(upd_taken), .up_target(upd_target)
  );

  assign pred_tk = lk_hit && lk_msb;

  logic [META_W-1:0] q_head;
  logic              q_empty, q_full;

  btb_meta_fifo #(.W(META_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst),
    .push(req_val), .din({pred_tk, lk_lane}),
    .pop(rsp_val), .dout(q_head),
    .empty(q_empty), .full(q_full)
  );

  logic [LANES-1:0] m_active, m_flag;

  btb_lane_mask #(.LANES(LANES)) u_mask (
    .taken(q_head[META_W-1]), .lane(q_head[LANE_W-1:0]),
    .active(m_active), .flag(m_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_val    <= 1'b0;
      redir_target <= '0;
      out_val      <= 1'b0;
      out_active   <= '0;
      out_taken    <= '0;
    end else begin
      redir_val <= req_val && pred_tk;
      if (req_val) redir_target <= lk_target;
      out_val <= rsp_val && !rsp_drop;
      if (rsp_val) begin
        out_active <= m_active;
        out_taken  <= m_flag;
      end
    end
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_val,
  input logic             rsp_val,
  input logic             rsp_drop,
  input logic             redir_val,
  input logic             out_val,
  input logic [LANES-1:0] out_active,
  input logic [LANES-1:0] out_taken,
  input logic             q_full,
  input logic             q_empty
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!redir_val && !out_val)); // R1
  AST_REDIR_CAUSE: assert property (@(posedge clk) disable iff (rst) redir_val |-> $past(req_val)); // R2
  AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (rst) out_val |-> $past(rsp_val && !rsp_drop)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (req_val && !rsp_val) |-> !q_full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rsp_val |-> !q_empty); // R8
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst) $onehot0(out_taken)); // R9
  AST_FLAG_ACTIVE: assert property (@(posedge clk) disable iff (rst) out_val |-> ((out_taken & ~out_active) == '0)); // R9
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst) (rsp_val && rsp_drop) |=> !out_val); // R10
endmodule

bind btb_predictor btb_predictor_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .req_val(req_val), .rsp_val(rsp_val), .rsp_drop(rsp_drop),
  .redir_val(redir_val), .out_val(out_val), .out_active(out_active),
  .out_taken(out_taken), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/sim_btb_predictor.sv
`timescale 1ns/1ps
module sim_btb_predictor;
  localparam int AW = 32;
  localparam int NL = 4;
  localparam int NS = 8;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_val = 0, rsp_val = 0, rsp_drop = 0, upd_val = 0, upd_taken = 0;
  logic [AW-1:0] req_addr = '0, upd_pc = '0, upd_target = '0;
  logic redir_val, out_val;
  logic [AW-1:0] redir_target;
  logic [NL-1:0] out_active, out_taken;

  always #4 clk = ~clk;

  btb_predictor u0 (
    .clk(clk), .rst(rst), .req_val(req_val), .req_addr(req_addr),
    .redir_val(redir_val), .redir_target(redir_target),
    .rsp_val(rsp_val), .rsp_drop(rsp_drop),
    .out_val(out_val), .out_active(out_active), .out_taken(out_taken),
    .upd_val(upd_val), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  int n_chk = 0, n_bad = 0, outst = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(input string r, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // reference model: per-set queues in allocation order, metadata queue
  typedef struct packed {
    logic [27:0] tg;
    logic [31:0] tgt;
    logic [1:0]  ctr;
    logic [1:0]  ln;
  } ment_t;
  ment_t mtab[NS][$];
  bit    mq_t[$];
  int    mq_l[$];
  bit e_redir = 0, e_out = 0, hh, tk;
  logic [AW-1:0] e_tgt = '0;
  logic [NL-1:0] e_act = '0, e_flg = '0;
  int s, ln, hi;
  ment_t ne;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NS; k++) mtab[k].delete();
      mq_t.delete(); mq_l.delete();
      e_redir = 0; e_out = 0;
    end else begin
      // lookup on state before this cycle's update (R7)
      e_redir = 0;
      if (req_val) begin
        s = int'(req_addr[6:4]); hh = 0; tk = 0; ln = 0;
        foreach (mtab[s][i])
          if (!hh && mtab[s][i].tg == req_addr[31:4]) begin
            hh = 1; tk = mtab[s][i].ctr[1]; ln = int'(mtab[s][i].ln);
            if (tk) e_tgt = mtab[s][i].tgt;
          end
        e_redir = tk;
      end
      e_out = 0;
      if (rsp_val && mq_t.size() > 0) begin
        bit pt; int pl;
        pt = mq_t.pop_front(); pl = mq_l.pop_front();
        e_out = !rsp_drop;
        for (int i = 0; i < NL; i++) begin
          e_act[i] = !pt || (i <= pl);
          e_flg[i] = pt && (i == pl);
        end
      end
      if (req_val) begin mq_t.push_back(tk); mq_l.push_back(ln); end
      if (upd_val) begin
        s = int'(upd_pc[6:4]); hi = -1;
        foreach (mtab[s][i]) if (hi < 0 && mtab[s][i].tg == upd_pc[31:4]) hi = i;
        if (hi >= 0) begin
          if (upd_taken && mtab[s][hi].ctr != 3) mtab[s][hi].ctr++;
          if (!upd_taken && mtab[s][hi].ctr != 0) mtab[s][hi].ctr--;
        end else begin
          ne.tg = upd_pc[31:4]; ne.tgt = upd_target; ne.ln = upd_pc[3:2];
          ne.ctr = upd_taken ? 2'd2 : 2'd1;
          if (mtab[s].size() == 2) void'(mtab[s].pop_front());
          mtab[s].push_back(ne);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({tag, " model redir_val"}, AW'(redir_val), AW'(e_redir));
      if (e_redir) chk({tag, " model redir_target"}, redir_target, e_tgt);
      chk({tag, " model out_val"}, AW'(out_val), AW'(e_out));
      if (e_out) begin
        chk({tag, " model out_active"}, AW'(out_active), AW'(e_act));
        chk({tag, " model out_taken"}, AW'(out_taken), AW'(e_flg));
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
    req_val = 0; rsp_val = 0; rsp_drop = 0; upd_val = 0;
  endtask

  task automatic look(input logic [AW-1:0] a);
    req_val = 1; req_addr = a; outst++; tick();
  endtask

  task automatic resp(input bit d);
    rsp_val = 1; rsp_drop = d; outst--; tick();
  endtask

  task automatic upd(input logic [AW-1:0] pc, input bit t, input logic [AW-1:0] tg);
    upd_val = 1; upd_pc = pc; upd_taken = t; upd_target = tg; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 redir after reset", AW'(redir_val), 0);
    chk("R1 out_val after reset", AW'(out_val), 0);
    look(32'h100); chk("R1 empty table", AW'(redir_val), 0);
    resp(0); chk("R9 no-pred active", AW'(out_active), 32'hF);
    chk("R9 no-pred flag", AW'(out_taken), 0);

    tag = "R5";
    upd(32'h108, 1, 32'h400);
    look(32'h100);
    chk("R2 redir", AW'(redir_val), 1); chk("R5 target", redir_target, 32'h400);
    resp(0);
    chk("R9 active lanes 0..2", AW'(out_active), 32'h7);
    chk("R9 flag lane 2", AW'(out_taken), 32'h4);

    tag = "R4";
    upd(32'h108, 0, 0); upd(32'h108, 0, 0);
    look(32'h100); chk("R4 dec to 0", AW'(redir_val), 0); resp(0);
    repeat (4) upd(32'h108, 1, 0);
    look(32'h100); chk("R4 top saturate", AW'(redir_val), 1); resp(0);
    repeat (4) upd(32'h108, 0, 0);
    repeat (2) upd(32'h108, 1, 0);
    look(32'h100); chk("R4 bottom saturate", AW'(redir_val), 1); resp(0);

    tag = "R5";
    upd(32'h20C, 0, 32'h900);
    look(32'h200); chk("R5 weak not-taken", AW'(redir_val), 0); resp(0);
    upd(32'h20C, 1, 0);
    look(32'h200); chk("R5 weak->taken", AW'(redir_val), 1);
    chk("R5 target kept", redir_target, 32'h900);
    resp(0); chk("R9 flag lane 3", AW'(out_taken), 32'h8);

    tag = "R6";
    upd(32'h1014, 1, 32'hA00); upd(32'h1094, 1, 32'hB00); upd(32'h1114, 1, 32'hC00);
    look(32'h1010); chk("R6 oldest evicted", AW'(redir_val), 0); resp(0);
    look(32'h1090); chk("R6 second kept", redir_target, 32'hB00); resp(0);
    look(32'h1110); chk("R6 newest kept", AW'(redir_val), 1); resp(0);
    look(32'h100); chk("R3 other set untouched", AW'(redir_val), 1); resp(0);

    tag = "R7";
    req_val = 1; req_addr = 32'h3000; outst++;
    upd_val = 1; upd_pc = 32'h3000; upd_taken = 1; upd_target = 32'hD00;
    tick(); chk("R7 pre-update view", AW'(redir_val), 0);
    look(32'h3000); chk("R7 next lookup hits", AW'(redir_val), 1);
    resp(0); resp(0);

    tag = "R10";
    look(32'h3000); resp(1); chk("R10 drop silent", AW'(out_val), 0);

    tag = "R8";
    look(32'h3000); look(32'h5000);
    resp(0); chk("R8 first in order", AW'(out_taken), 32'h1);
    resp(0); chk("R8 second in order", AW'(out_active), 32'hF);

    tag = "R3 random";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 99) < 45 && outst > 0) begin
        rsp_val = 1; rsp_drop = ($urandom_range(0, 3) == 0); outst--;
      end
      if ($urandom_range(0, 99) < 50 && outst < QD) begin
        req_val = 1; req_addr = 32'h8000 + 32'($urandom_range(0, 31)) * 16; outst++;
      end
      if ($urandom_range(0, 99) < 35) begin
        upd_val = 1;
        upd_pc = 32'h8000 + 32'($urandom_range(0, 31)) * 16 + 32'($urandom_range(0, 3)) * 4;
        upd_taken = ($urandom_range(0, 99) < 60);
        upd_target = $urandom;
      end
      tick();
    end
    while (outst > 0) resp(0);
    tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule